// File: doc/BRIEF.md
# Byte-Serialized Result Register Interface

This block holds four 16-bit conversion results and lets a bus master read them over an 8-bit data path. The conversion side loads any of the four results through a simple write port. The bus side reads each result as two byte accesses. The high-byte access returns the upper byte directly. In the same access, a shared 8-bit holding latch captures the lower byte of that result. The low-byte access returns what the latch holds, not the live lower byte.

This scheme keeps a two-access read coherent even when the conversion side updates the result between the two accesses, provided the master reads the high byte first. The master may read only the high byte. A low-byte read with no high-byte read before it returns whatever the latch last captured. Only one latch exists, so a high-byte read of any channel replaces its contents.

Top module: `byte_serial_result_if`

## Requirements
- R1: When `wr_en` is high at a clock edge, `wr_data` is stored into the result register of channel `wr_ch`. The other channels are left unchanged.
- R2: The byte address `rd_addr` equals channel index times two plus a byte select. Bits [2:1] hold the channel. Bit 0 selects the byte: 0 for the high byte and 1 for the low byte.
- R3: A high-byte read (`rd_en` high, bit 0 of `rd_addr` = 0) puts bits [15:8] of the selected result on `rd_data` one cycle after the request. For example, a result of 0xAA40 returns 0xAA.
- R4: A high-byte read copies bits [7:0] of the selected result into the holding latch at the same clock edge.
- R5: A low-byte read (`rd_en` high, bit 0 of `rd_addr` = 1) puts the holding latch on `rd_data` one cycle after the request. It never returns the live lower byte. For example, after the high-byte read of 0xAA40 it returns 0x40.
- R6: There is one holding latch for all channels. A high-byte read of any channel overwrites it. A low-byte read, or a cycle with no read, leaves it unchanged.
- R7: A write to a result register after a high-byte read, or in the same cycle as it, does not change the latched lower byte. A read and a write to the same channel in the same cycle return the value held before the write.
- R8: `rd_data` holds its last value while `rd_en` is low.
- R9: Reset (`rst_n` low) clears all result registers, the holding latch and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Conversion-side write strobe |
| wr_ch | input | 2 | Channel to write |
| wr_data | input | 16 | Result value to store |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 3 | Byte address: channel*2 + byte select |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |

## Verification
A corrupted result register shows up on the next high-byte read of that channel, one cycle after the request. A wrong latch value stays hidden until a low-byte read, which may come many cycles later. For that reason the bench pairs high and low reads with writes and reads of other channels between them. A latch that follows live data, or that fails to load, therefore gives a wrong low byte on the very next low-byte access.

// File: rtl/byte_serial_result_if.sv
module byte_serial_result_if #(
  parameter int NUM_CH = 4,
  parameter int BUS_W  = 8,
  localparam int RES_W  = 2 * BUS_W,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [RES_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data
);

  logic [RES_W-1:0] res_q [NUM_CH];
  logic [BUS_W-1:0] hold_q;

  wire [CH_W-1:0]  rd_ch  = rd_addr[ADDR_W-1:1];
  wire             rd_lo  = rd_addr[0];
  wire             rd_hi  = rd_en & ~rd_lo;
  wire [BUS_W-1:0] hi_sel = res_q[rd_ch][RES_W-1:BUS_W];
  wire [BUS_W-1:0] lo_sel = res_q[rd_ch][BUS_W-1:0];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (!rst_n)
        res_q[i] <= '0;
      else if (wr_en && wr_ch == CH_W'(i))
        res_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_lo ? hold_q : hi_sel;
      if (!rd_lo) hold_q <= lo_sel;
    end
  end

  AST_HIGH_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> rd_data == $past(hi_sel)); // R3
  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> hold_q == $past(lo_sel)); // R4
  AST_LOW_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_lo) |=> rd_data == $past(hold_q)); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hi |=> $stable(hold_q)); // R6
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0 && hold_q == '0)); // R9

endmodule

// File: tb/byte_serial_result_if_tb.sv
module byte_serial_result_if_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_ch = 0;
  logic [15:0] wr_data = 0;
  logic        rd_en = 0;
  logic [2:0]  rd_addr = 0;
  logic [7:0]  rd_data;

  byte_serial_result_if u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] m_res [4];
  logic [7:0]  m_hold;
  logic [7:0]  m_last;
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  bit          pend = 0;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit we, logic [1:0] wch, logic [15:0] wd,
                     bit re, logic [2:0] ra, string tag);
    @(posedge clk); #2;
    wr_en = we; wr_ch = wch; wr_data = wd; rd_en = re; rd_addr = ra;
    if (re) begin
      logic [7:0] e;
      if (ra[0]) e = m_hold;
      else begin
        e = m_res[ra[2:1]][15:8];
        m_hold = m_res[ra[2:1]][7:0];
      end
      m_last = e;
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    if (we) m_res[wch] = wd;
  endtask

  task automatic wr(logic [1:0] ch, logic [15:0] d);
    cyc(1, ch, d, 0, 0, "");
  endtask

  task automatic rd(logic [1:0] ch, bit lo, string tag);
    cyc(0, 0, 0, 1, {ch, lo}, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, "");
  endtask

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    pend = rd_en;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) m_res[i] = '0;
    m_hold = '0; m_last = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check("R9 rd_data after reset", rd_data, 8'h00);
    rd(0, 1, "R9 latch clear after reset");
    for (int c = 0; c < 4; c++) rd(2'(c), 0, "R9 result clear after reset");
    rd(3, 1, "R9 latch from cleared register");

    wr(0, 16'hAA40); wr(1, 16'h1234); wr(2, 16'hBEEF); wr(3, 16'h5A0F);
    rd(0, 0, "R3 high byte 0xAA40");
    rd(0, 1, "R5 low byte 0xAA40");
    for (int c = 0; c < 4; c++) begin
      rd(2'(c), 0, "R2 R3 high byte by channel");
      rd(2'(c), 1, "R2 R4 low byte by channel");
    end

    rd(1, 0, "R3 high ch1");
    wr(1, 16'h9876);
    wr(1, 16'h4321);
    rd(1, 1, "R7 low keeps pre-write byte");
    rd(1, 0, "R1 high after rewrite");
    rd(1, 1, "R1 low after rewrite");

    cyc(1, 2, 16'hC3D4, 1, 3'b100, "R7 read sees pre-write value");
    rd(2, 1, "R7 latch loaded before write");
    rd(2, 0, "R1 new value visible");

    rd(3, 0, "R3 high ch3");
    rd(0, 0, "R6 high ch0 overwrites latch");
    rd(3, 1, "R6 shared latch holds ch0 low");
    rd(3, 1, "R6 repeated low read no change");

    rd(2, 0, "R3 high-only read");
    rd(1, 0, "R3 high-only read other channel");
    rd(0, 0, "R3 high ch0");
    rd(0, 1, "R5 low after high-only reads");

    rd(1, 0, "R3 high ch1 before idle");
    wr(1, 16'h0000);
    idle(3);
    @(negedge clk);
    check("R8 rd_data holds while idle", rd_data, m_last);
    rd(1, 1, "R8 R6 latch kept across idle");
    idle(2);
    @(negedge clk);
    finish_run();
  end
endmodule